// File: doc/BRIEF.md
# Four-Step Bidirectional Switch Commutator

This block steers one output line of a three-phase direct AC-to-AC converter. Each of the line's bidirectional switches joins the line to one supply input. A switch is made of two transistors, one for each direction of current. The modulator asks for a supply input with a one-hot word. The block drives the two gates of every switch so that exactly one switch conducts in both directions while the line is at rest.

When the requested input changes, the block moves the load current from the old switch to the new one in four single-transistor steps. Each step is held for a fixed dwell time. The order of the steps depends on the sign of the load current, which is sampled when the move begins. In this order the load never sees an open circuit, and no two inputs are ever shorted together. Requests that arrive while a move is in progress are held back until the move ends. One instance serves each output line, and the instances do not interact.

Top module: `commut_line`

## Requirements
- R1: While reset is asserted, and after it is released, the switch for input 0 has both gates on (`gate_o == 6'b000011`) and every other gate is off. No move is in progress.
- R2: At rest, only the switch of the last completed target has both gates on (`gate_o[2k]` and `gate_o[2k+1]` for input k). All other gates are off.
- R3: With `cur_pos_i == 0` (negative current), a move from switch s to switch t applies, in order: gate 2s off, gate 2t+1 on, gate 2s+1 off, gate 2t on.
- R4: With `cur_pos_i == 1` (positive current), a move from switch s to switch t applies, in order: gate 2s+1 off, gate 2t on, gate 2s off, gate 2t+1 on.
- R5: Suppose `sel_i` holds a new valid target that differs from the current one at a rising edge E while the block is at rest. Step 1 is then visible after E, and step k is visible after edge E+(k-1)·DWELL. The block is back at rest after edge E+4·DWELL. A waiting request can start a new move at edge E+4·DWELL+1 at the earliest.
- R6: Changes of `sel_i` during a move do not alter that move. When the move ends, the value of `sel_i` at that moment is the next target, so the last request wins.
- R7: The current sign is taken only at the start of a move. Changing `cur_pos_i` during a move does not change its step order.
- R8: A `sel_i` that is all zeros, has more than one bit set, or equals the current switch starts nothing, and the gates stay unchanged.
- R9: At no time are transistor 1 (even bit) of one switch and transistor 2 (odd bit) of a different switch on together. At least one gate is always on.
- R10: At most one gate bit changes per clock cycle, and two gate changes within a move are at least DWELL cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | N | One-hot requested supply input (bit k = input k) |
| cur_pos_i | input | 1 | Load current sign: 1 positive, 0 negative |
| gate_o | output | 2·N | Gate drives: bit 2k is transistor 1 of switch k, bit 2k+1 is transistor 2 |

## Verification
The hardest situation to reach is a request, or a sign reversal, arriving in the middle of a move, especially several conflicting requests in one move, some of them invalid. The stimulus changes `sel_i` and `cur_pos_i` at random cycles inside each move. It sometimes changes the request twice, to random three-bit values that include zero and multi-bit words. Each gate word is then checked cycle by cycle against the order fixed at the start of the move. A directed case places two valid requests in one move and confirms that only the later one is carried out.

// File: rtl/commut_pkg.sv
package commut_pkg;

    // Sequencer phase; S1..S4 hold the gate pattern of steps 1..4.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_S1   = 3'd1,
        PH_S2   = 3'd2,
        PH_S3   = 3'd3,
        PH_S4   = 3'd4
    } phase_e;

endpackage

// File: rtl/commut_dwell_timer.sv
module commut_dwell_timer #(
    parameter int DWELL = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        done_o = run_i && (cnt_q == LAST);
        if (restart_i || done_o) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/commut_step_decode.sv
module commut_step_decode #(
    parameter int N = 3
) (
    input  logic [N-1:0]   src_i,
    input  logic [N-1:0]   dst_i,
    input  logic           first_i,  // 1: transistor 2 leaves first
    input  logic [1:0]     step_i,   // 0..3 = steps 1..4
    output logic [2*N-1:0] gate_o
);
    for (genvar k = 0; k < N; k++) begin : g_sw
        logic on_other;
        logic on_first;
        always_comb begin
            // the transistor that is not switched first carries the current
            on_other = (src_i[k] && (step_i <= 2'd1)) || (dst_i[k] && (step_i >= 2'd1));
            on_first = dst_i[k] && (step_i == 2'd3);
            gate_o[2*k]   = first_i ? on_other : on_first;
            gate_o[2*k+1] = first_i ? on_first : on_other;
        end
    end
endmodule

// File: rtl/commut_line.sv
module commut_line
    import commut_pkg::*;
#(
    parameter int N     = 3,
    parameter int DWELL = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   sel_i,
    input  logic           cur_pos_i,
    output logic [2*N-1:0] gate_o
);
    localparam logic [2*N-1:0] RST_GATE = {{(2*N-2){1'b0}}, 2'b11};
    localparam logic [N-1:0]   RST_SEL  = {{(N-1){1'b0}}, 1'b1};

    typedef struct packed {
        phase_e         phase;
        logic [N-1:0]   cur;
        logic [N-1:0]   dst;
        logic           pos;
        logic [2*N-1:0] gate;
    } st_t;

    st_t st_d, st_q;

    logic           idle;
    logic           sel_ok;
    logic           tmr_restart;
    logic           tmr_done;
    logic [N-1:0]   dec_dst;
    logic           dec_first;
    logic [1:0]     dec_step;
    logic [2:0]     ph_bits;
    logic [2*N-1:0] dec_gate;

    always_comb begin
        idle      = (st_q.phase == PH_IDLE);
        sel_ok    = $onehot(sel_i);
        ph_bits   = st_q.phase;
        dec_dst   = idle ? sel_i : st_q.dst;
        dec_first = idle ? cur_pos_i : st_q.pos;
        dec_step  = idle ? 2'd0 : ph_bits[1:0];
    end

    commut_step_decode #(.N(N)) u_dec (
        .src_i   (st_q.cur),
        .dst_i   (dec_dst),
        .first_i (dec_first),
        .step_i  (dec_step),
        .gate_o  (dec_gate)
    );

    commut_dwell_timer #(.DWELL(DWELL)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (tmr_restart),
        .run_i     (!idle),
        .done_o    (tmr_done)
    );

    always_comb begin
        st_d        = st_q;
        tmr_restart = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (sel_ok && (sel_i != st_q.cur)) begin
                    st_d.phase  = PH_S1;
                    st_d.dst    = sel_i;
                    st_d.pos    = cur_pos_i;
                    st_d.gate   = dec_gate;
                    tmr_restart = 1'b1;
                end
            end
            PH_S1, PH_S2, PH_S3: begin
                if (tmr_done) begin
                    st_d.phase = phase_e'(ph_bits + 3'd1);
                    st_d.gate  = dec_gate;
                end
            end
            PH_S4: begin
                if (tmr_done) begin
                    st_d.phase = PH_IDLE;
                    st_d.cur   = st_q.dst;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cur   <= RST_SEL;
            st_q.dst   <= RST_SEL;
            st_q.pos   <= 1'b0;
            st_q.gate  <= RST_GATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.gate;
endmodule

// File: rtl/commut_line_chk.sv
module commut_line_chk #(
    parameter int N     = 3,
    parameter int DWELL = 20
) (
    input logic           clk,
    input logic           rst_n,
    input logic [2*N-1:0] gate_o
);
    localparam int SW = $clog2(DWELL + 1);
    localparam logic [2*N-1:0] RST_GATE = {{(2*N-2){1'b0}}, 2'b11};

    logic [N-1:0]   t1, t2;
    logic [2*N-1:0] prev_q;
    logic [SW-1:0]  since_q;
    logic           armed_q;
    logic           chg;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            t1[k] = gate_o[2*k];
            t2[k] = gate_o[2*k+1];
        end
        chg = (gate_o != prev_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= RST_GATE;
            since_q <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q <= gate_o;
            if (chg) begin
                since_q <= '0;
                armed_q <= 1'b1;
            end else if (since_q != SW'(DWELL)) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    AST_NO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        ((t1 != '0) && (t2 != '0)) |-> ((t1 == t2) && $onehot(t1))); // R9
    AST_NEVER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o != '0)); // R9
    AST_ONE_EDGE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(gate_o ^ prev_q) <= 1)); // R10
    AST_STEP_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && armed_q) |-> (since_q >= SW'(DWELL - 1))); // R10
endmodule

bind commut_line commut_line_chk #(.N(N), .DWELL(DWELL)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_o (gate_o)
);

// File: tb/tb_commut_line.sv
module tb_commut_line;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 3;
    localparam int D  = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] sel_i = 3'b001;
    logic         cur_pos_i = 1'b0;
    logic [5:0]   gate_o;

    int total = 0;
    int bad = 0;
    int cur_i = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    commut_line #(.N(N), .DWELL(D)) dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .cur_pos_i(cur_pos_i), .gate_o(gate_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] rest_gates(input int s);
        logic [5:0] g = '0;
        g[2*s] = 1'b1; g[2*s+1] = 1'b1;
        return g;
    endfunction

    // step k (1..4) per R3 / R4
    function automatic logic [5:0] step_gates(input int s, input int t, input bit pos, input int k);
        logic [5:0] g = '0;
        int o = pos ? 0 : 1;  // transistor still conducting after step 1
        case (k)
            1: g[2*s+o] = 1'b1;
            2: begin g[2*s+o] = 1'b1; g[2*t+o] = 1'b1; end
            3: g[2*t+o] = 1'b1;
            default: begin g[2*t] = 1'b1; g[2*t+1] = 1'b1; end
        endcase
        return g;
    endfunction

    function automatic int oh_idx(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return 0;
    endfunction

    // global monitor: R9 and R10
    logic [5:0] prev_g;
    always @(negedge clk) begin
        if (mon_en) begin
            logic [2:0] a1, a2;
            for (int k = 0; k < N; k++) begin a1[k] = gate_o[2*k]; a2[k] = gate_o[2*k+1]; end
            chk(!(a1 != 0 && a2 != 0) || (a1 == a2 && $onehot(a1)), "R9 short", gate_o, prev_g);
            chk(gate_o != 0, "R9 open", gate_o, 6'b0);
            chk($countones(gate_o ^ prev_g) <= 1, "R10 edges", gate_o, prev_g);
        end
        prev_g = gate_o;
    end

    // called just after a negedge; returns just after a negedge at rest
    task automatic run_seq(input int t, input bit pos, input int m1_at, input logic [2:0] m1_sel,
                           input int m2_at, input logic [2:0] m2_sel);
        int s = cur_i;
        sel_i = 3'b000; sel_i[t] = 1'b1;
        cur_pos_i = pos;
        @(posedge clk);
        for (int j = 0; j < 4*D; j++) begin
            string tag;
            @(negedge clk);
            if (m1_at >= 0 && j > m1_at) tag = "R6 R7";
            else if (j % D == 0 || j % D == D-1) tag = "R5";
            else tag = pos ? "R4" : "R3";
            chk(gate_o == step_gates(s, t, pos, j/D + 1), tag, gate_o, step_gates(s, t, pos, j/D + 1));
            if (j == m1_at) begin sel_i = m1_sel; cur_pos_i = ~pos; end
            if (j == m2_at) sel_i = m2_sel;
        end
        @(negedge clk);
        chk(gate_o == rest_gates(t), "R2 rest", gate_o, rest_gates(t));
        cur_i = t;
    endtask

    task automatic hold_check(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(gate_o == rest_gates(cur_i), tag, gate_o, rest_gates(cur_i));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(gate_o == 6'b000011, "R1 in reset", gate_o, 6'b000011);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gate_o == 6'b000011, "R1 after reset", gate_o, 6'b000011);
        prev_g = gate_o;
        mon_en = 1'b1;
        hold_check(3, "R1 steady");

        // R3: A to B, negative current
        run_seq(1, 1'b0, -1, 3'b0, -1, 3'b0);
        // R4: B to C, positive current
        run_seq(2, 1'b1, -1, 3'b0, -1, 3'b0);

        // R8: invalid and same-as-current requests
        sel_i = 3'b000; hold_check(25, "R8 zero");
        sel_i = 3'b011; hold_check(25, "R8 multi");
        sel_i = 3'b111; hold_check(5, "R8 all");
        sel_i = 3'b100; hold_check(5, "R8 same");

        // R6: two requests in one move, the later one wins; R7 sign flipped
        run_seq(0, 1'b0, 5, 3'b010, 30, 3'b100);
        run_seq(2, 1'b1, -1, 3'b0, -1, 3'b0);

        // R5: back-to-back with pending request (start at 4*D+1)
        run_seq(1, 1'b1, 70, 3'b001, -1, 3'b0);
        run_seq(0, 1'b0, -1, 3'b0, -1, 3'b0);

        // random moves with mid-move disturbances
        for (int it = 0; it < 40; it++) begin
            int t, m1, m2;
            logic [2:0] s1, s2;
            if ($onehot(sel_i) && oh_idx(sel_i) != cur_i) begin
                t = oh_idx(sel_i);
            end else begin
                hold_check(2, "R8 idle");
                t = (cur_i + 1 + int'($urandom_range(0, 1))) % N;
            end
            m1 = ($urandom_range(0, 3) == 0) ? -1 : int'($urandom_range(0, 4*D-3));
            s1 = 3'($urandom_range(0, 7));
            m2 = (m1 >= 0 && $urandom_range(0, 1) == 1) ? m1 + 1 + int'($urandom_range(0, 4*D-3-m1)) : -1;
            s2 = 3'($urandom_range(0, 7));
            run_seq(t, 1'($urandom_range(0, 1)), m1, s1, m2, s2);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule